// File: doc/BRIEF.md
# Keyboard Edge/Level Interrupt Controller

This block watches a small group of external input pins and merges them into a single interrupt request. Each pin has its own enable bit and its own polarity bit. The polarity bit sets both the edge direction and the level that count as active for that pin. Every pin passes through a two-flop synchroniser before it is compared with its previous value.

A mode bit chooses how the shared flag is set. In edge-only mode, an active-going edge on an enabled pin sets the flag. In edge-plus-level mode, an enabled pin that is held at its active level also keeps the flag set. Software clears the flag by writing 1 to an acknowledge bit. An interrupt-enable bit gates the request output. The flag can still be polled while the request is gated off.

Software should configure the pins first, then acknowledge to clear any false flag, and only then set the interrupt enable. The block has no clock gating, so it keeps watching the pins during low-power waits and can act as a wakeup source.

Top module: `kbd_irq`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq_o` is 0.
- R2: The register at address 0 holds the mode (bit 0, 1 = edge plus level), the interrupt enable (bit 1), the acknowledge (bit 2, always reads 0) and the read-only flag (bit 3). Address 1 holds the pin enables and address 2 holds the polarities, bit i for pin i. Writes to the flag bit have no effect.
- R3: With polarity 1, a rising edge on an enabled pin sets the flag on the third rising clock edge after the pin changes.
- R4: With polarity 0, a falling edge on an enabled pin sets the flag. A rising edge on that pin does not.
- R5: Edges on disabled pins never set the flag.
- R6: `irq_o` is high only while both the flag and the interrupt enable are 1. With the enable at 0, the flag still sets and can be read.
- R7: In edge-only mode, an acknowledge clears the flag, even while the pin stays at its active level.
- R8: In edge-plus-level mode, an enabled pin held at its active level sets the flag. An acknowledge leaves the flag set until no enabled pin is active.
- R9: Enabling a pin that already sits at its active level does not set the flag. Changing a pin's polarity so that its current level becomes active does not set the flag either.
- R10: If a detected edge and an acknowledge land in the same clock cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPIN | Asynchronous external pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control/status, 1 enables, 2 polarities) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets the cases where a careless design raises a false flag.

- **Reconfiguration:** enabling a pin already at its active level, or flipping a polarity under a steady pin, must not set the flag. A design that does not re-sample the previous value would flag a phantom edge.
- **Acknowledge in level mode:** an acknowledge while the level is still active must leave the flag set. A design that gives the acknowledge priority would drop a pending request.
- **Edge and acknowledge together:** an edge that arrives in the same cycle as an acknowledge must survive. Getting this wrong loses a key press.
- **Gating and read-back:** the interrupt enable must gate only the request, not the flag. The acknowledge bit must read back as zero.

// File: rtl/kbd_irq.sv
module kbd_irq #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            irq_o
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_POL  = 2'd2;

  logic [NPIN-1:0] s1, s2, prev_act, act, pol_d;
  logic [7:0]      pin_en_q, pol_q;
  logic            mode_q, ie_q, flag_q;
  logic            wr_ctrl, wr_en_reg, wr_pol, ack, edge_hit, level_hit, set;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_en_reg = wr_en && (addr == A_EN);
  assign wr_pol    = wr_en && (addr == A_POL);
  assign ack       = wr_ctrl && wdata[2];

  assign pol_d     = wr_pol ? wdata[NPIN-1:0] : pol_q[NPIN-1:0];
  assign act       = ~(s2 ^ pol_q[NPIN-1:0]);
  assign edge_hit  = |(pin_en_q[NPIN-1:0] & act & ~prev_act);
  assign level_hit = |(pin_en_q[NPIN-1:0] & act);
  assign set       = edge_hit || (mode_q && level_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= '0;
      s2       <= '0;
      prev_act <= '1;
      pin_en_q <= '0;
      pol_q    <= '0;
      mode_q   <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      s1       <= pin_i;
      s2       <= s1;
      prev_act <= ~(s2 ^ pol_d);
      if (wr_ctrl) begin
        mode_q <= wdata[0];
        ie_q   <= wdata[1];
      end
      if (wr_en_reg) pin_en_q <= wdata;
      if (wr_pol)    pol_q    <= wdata;
      flag_q <= set || (flag_q && !ack);
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {4'b0, flag_q, 1'b0, ie_q, mode_q};
      A_EN:    rdata = pin_en_q;
      A_POL:   rdata = pol_q;
      default: rdata = 8'h00;
    endcase
  end

  assign irq_o = flag_q && ie_q;
endmodule

// File: rtl/kbd_irq_chk.sv
module kbd_irq_chk #(
  parameter int NPIN = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq_o,
  input logic       flag_q,
  input logic       ie_q,
  input logic       mode_q,
  input logic [7:0] pin_en_q,
  input logic       level_hit
);
  a_r1_flag_clear_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !flag_q);

  a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[2] == 1'b0));

  a_r5_flag_needs_enabled_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(pin_en_q[NPIN-1:0]) != '0));

  a_r6_irq_needs_flag_and_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q && ie_q));

  a_r7_flag_falls_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_en && addr == 2'd0 && wdata[2]));

  a_r8_level_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && level_hit) |=> flag_q);
endmodule

bind kbd_irq kbd_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_o(irq_o), .flag_q(flag_q), .ie_q(ie_q),
  .mode_q(mode_q), .pin_en_q(pin_en_q), .level_hit(level_hit)
);

// File: tb/kbd_irq_tb.sv
`timescale 1ns/1ps
module kbd_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_o;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  kbd_irq #(.NPIN(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // fields: enable, polarity, pins before, pins after, expected flag (edge mode)
  localparam logic [32:0] VEC [8] = '{
    {8'h01, 8'h01, 8'h00, 8'h01, 1'b1},  // R3 rising edge
    {8'h01, 8'h00, 8'h01, 8'h00, 1'b1},  // R4 falling edge
    {8'h01, 8'h00, 8'h00, 8'h01, 1'b0},  // R4 rising ignored
    {8'h00, 8'hFF, 8'h00, 8'hFF, 1'b0},  // R5 all disabled
    {8'h80, 8'h80, 8'h00, 8'h80, 1'b1},  // R3 top pin
    {8'hF0, 8'h0F, 8'h00, 8'h0F, 1'b0},  // R5 only disabled pins move
    {8'h0F, 8'h00, 8'h0F, 8'h0E, 1'b1},  // R4 one falling among many
    {8'hFF, 8'hAA, 8'h55, 8'h55, 1'b0}   // R3 no movement
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 enable", d, 8'h00);
    rd(2'd2, d); check("R1 polarity", d, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);

    // R2 read-back; ack reads 0, flag bit not writable
    wr(2'd0, 8'h0F); rd(2'd0, d); check("R2 ctrl", d, 8'h03);
    wr(2'd1, 8'hA5); rd(2'd1, d); check("R2 enable", d, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, d); check("R2 polarity", d, 8'h3C);
    wr(2'd1, 8'h00); wr(2'd0, 8'h04);

    // table walk, edge mode, interrupt enabled
    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][32:25]);
      wr(2'd2, VEC[i][24:17]);
      pin_i = VEC[i][16:9];
      tick(5);
      wr(2'd0, 8'h06);
      tick(2);
      pin_i = VEC[i][8:1];
      tick(5);
      rd(2'd0, d);
      check("R3/R4/R5 flag", {7'b0, d[3]}, {7'b0, VEC[i][0]});
      check("R6 irq", {7'b0, irq_o}, {7'b0, VEC[i][0]});
    end

    // reset pins and config
    wr(2'd1, 8'h00); pin_i = 8'h00; tick(4); wr(2'd0, 8'h04);

    // R6 gating: flag polls with enable off
    wr(2'd2, 8'h01); wr(2'd1, 8'h01); wr(2'd0, 8'h04);
    pin_i = 8'h01; tick(5);
    rd(2'd0, d); check("R6 flag polled", d, 8'h08);
    check("R6 irq gated", {7'b0, irq_o}, 8'h00);
    wr(2'd0, 8'h02); tick(1);
    check("R6 irq on", {7'b0, irq_o}, 8'h01);

    // R7 ack in edge mode clears while pin still active
    wr(2'd0, 8'h06); tick(2);
    rd(2'd0, d); check("R7 ack clears", d, 8'h02);

    // R8 level mode
    wr(2'd0, 8'h03); tick(2);
    rd(2'd0, d); check("R8 level sets", d, 8'h0B);
    wr(2'd0, 8'h07); tick(2);
    rd(2'd0, d); check("R8 ack held", d, 8'h0B);
    pin_i = 8'h00; tick(4);
    wr(2'd0, 8'h07); tick(2);
    rd(2'd0, d); check("R8 ack after release", d, 8'h03);

    // R9 enabling an already active pin
    wr(2'd0, 8'h04); wr(2'd1, 8'h00); wr(2'd2, 8'h01);
    pin_i = 8'h01; tick(5); wr(2'd0, 8'h04);
    wr(2'd1, 8'h01); tick(5);
    rd(2'd0, d); check("R9 enable no flag", d, 8'h00);
    // R9 polarity flip under a steady low pin
    wr(2'd1, 8'h02); wr(2'd2, 8'h02); wr(2'd0, 8'h04);
    wr(2'd2, 8'h00); tick(5);
    rd(2'd0, d); check("R9 polarity no flag", d, 8'h00);

    // R10 edge and ack in the same cycle
    wr(2'd1, 8'h01); wr(2'd2, 8'h01); pin_i = 8'h00; tick(5); wr(2'd0, 8'h04);
    @(negedge clk); pin_i = 8'h01;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'h04;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
    rd(2'd0, d); check("R10 edge wins", d, 8'h08);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule